// File: doc/BRIEF.md
# I2C Target with Split Register Windows

This block is a bus target on a two-wire serial bus with a 7-bit address. A controller on the bus reaches a small register file through one byte-wide pointer that advances by itself after every byte. The pointer can point into two windows that do not touch. The low window holds eight general bytes at pointers 0 to 7. In that window byte 0 reflects a set of status inputs and byte 1 drives eight output lines. The upper window starts at pointer 0x20 and holds five system bytes: a version code, a command byte, the bus address byte and two delay settings.

In a write, the controller first sends the address. The byte after it becomes the new pointer. Every later byte is stored at the pointer, and the pointer then advances. In a read, bytes come from the pointer onward. A pointer that was never loaded since the last write addressing counts as register 0. The block answers with NACK for any pointer, or any access, that falls outside both windows.

The line interface is bit-serial open drain, so there is no valid/ready pairing. The block never stretches the clock and applies no back-pressure: it accepts or refuses each byte through the acknowledge bit. The settings appear as plain register outputs.

Top module: `i2c_dual_window_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the active address, which is 0x4F after reset. Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: Every write addressing sets the pointer to the "no pointer" value 0xFF. The first data byte after it is acknowledged and loaded as the pointer only when it lies in 0..7 or in 0x20..0x24; otherwise it is refused with NACK.
- R3: Each further write byte at a valid pointer is stored and acknowledged, and the pointer then increments by one. A byte at a pointer outside both windows (for example 8 or 0x25) is refused with NACK and not stored.
- R4: A read that starts while the pointer holds 0xFF begins at register 0. Each byte sent advances the pointer by one.
- R5: A read at a pointer outside both windows drives no data, so the controller sees 0xFF. The block then releases the bus until the next START, and the pointer stays where it was.
- R6: Register 0 reads the live value of `status_in`. A write to register 0 is acknowledged and has no effect. Bit i of register 1 drives `out_lines[i]`.
- R7: The system window maps 0x20 to version (read-only, value 2), 0x21 to command (reset 0x00), 0x22 to address (reset 0x4F), 0x23 to the input off-delay (reset 0x20) and 0x24 to the output off-delay (reset 0xFF). A write to 0x20 is acknowledged and ignored.
- R8: A byte written to 0x22 reads back as written. It becomes the active address only at the next STOP. A value outside 0x20..0x4F makes the active address 0x4F.
- R9: The block changes its SDA drive only while SCL is low.
- R10: After reset SDA is released, `out_lines` is 0x00, and the settings outputs hold their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| status_in | input | 8 | Status bits read through register 0 |
| out_lines | output | 8 | Output lines driven from register 1 |
| addr_active | output | 7 | Bus address currently matched |
| cmd_byte | output | 8 | Command setting |
| in_off_delay | output | 8 | Input off-delay setting |
| out_off_delay | output | 8 | Output off-delay setting |

## Verification
The bench builds the block with its default parameters: an eight-byte low window, the upper window based at 0x20, address limits 0x20 and 0x4F, and reset address 0x4F. These values make the window edges reachable with single-byte pointers: 7 against 8, 0x1F against 0x20, and 0x24 against 0x25. The same pointers also exercise the NACK path at each edge. The address-byte tests move the active address to 0x30 and back to 0x4F through a value that lies below the allowed range. This shows the delay until STOP and the substitution of the default.

// File: rtl/i2cdw_pkg.sv
package i2cdw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } link_state_e;

  localparam logic [7:0] PTR_NONE = 8'hFF;
  localparam int         SYS_REGS = 5;
endpackage

// File: rtl/i2cdw_sync.sv
module i2cdw_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cdw_link.sv
module i2cdw_link
  import i2cdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] dev_addr,
  input  logic       rx_accept,
  input  logic       rd_ok,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_clear,
  output logic       rx_stb,
  output logic [7:0] rx_byte,
  output logic       rd_adv
);
  link_state_e state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, txreg;
  logic        is_read, mack;
  logic        byte_end, addr_hit, rd_load;

  assign byte_end  = scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == dev_addr);
  assign ptr_clear = (state == ST_ADDR) && byte_end && addr_hit && !shreg[0];
  assign rx_stb    = (state == ST_WR) && byte_end;
  assign rx_byte   = shreg;
  assign rd_load   = scl_fall && (((state == ST_ADDR_ACK) && is_read) ||
                                  ((state == ST_RD_ACK) && mack));
  assign rd_adv    = rd_load && rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= 4'd0;
      shreg   <= 8'h00;
      txreg   <= 8'hFF;
      sda_oe  <= 1'b0;
      is_read <= 1'b0;
      mack    <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (rd_load) begin
      if (rd_ok) begin
        txreg  <= {rd_data[6:0], 1'b1};
        sda_oe <= ~rd_data[7];
        bitcnt <= 4'd1;
        state  <= ST_RD;
      end else begin
        sda_oe <= 1'b0;
        state  <= ST_IDLE;
      end
    end else begin
      unique case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            bitcnt <= 4'd0;
            if (state == ST_ADDR) begin
              if (addr_hit) begin
                sda_oe  <= 1'b1;
                is_read <= shreg[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (rx_accept) begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              sda_oe <= ~txreg[7];
              txreg  <= {txreg[6:0], 1'b1};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cdw_regbank.sv
module i2cdw_regbank
  import i2cdw_pkg::*;
#(
  parameter int         DATA_REGS   = 8,
  parameter logic [7:0] SYS_BASE    = 8'h20,
  parameter logic [6:0] DEV_ADDR    = 7'h4F,
  parameter logic [6:0] ADDR_MIN    = 7'h20,
  parameter logic [6:0] ADDR_MAX    = 7'h4F,
  parameter logic [7:0] VERSION     = 8'd2,
  parameter logic [7:0] IN_DLY_RST  = 8'h20,
  parameter logic [7:0] OUT_DLY_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptr_clear,
  input  logic       rx_stb,
  input  logic [7:0] rx_byte,
  input  logic       rd_adv,
  input  logic       stop_det,
  input  logic [7:0] status_in,
  output logic       rx_accept,
  output logic       rd_ok,
  output logic [7:0] rd_data,
  output logic [7:0] out_lines,
  output logic [7:0] cmd_byte,
  output logic [6:0] addr_active,
  output logic [7:0] in_off_delay,
  output logic [7:0] out_off_delay
);
  localparam int         IDX_W    = (DATA_REGS > 1) ? $clog2(DATA_REGS) : 1;
  localparam logic [7:0] DATA_END = 8'(DATA_REGS);
  localparam logic [7:0] SYS_END  = SYS_BASE + 8'(SYS_REGS);

  function automatic logic in_win(input logic [7:0] p);
    return (p < DATA_END) || (p >= SYS_BASE && p < SYS_END);
  endfunction

  logic [7:0] ptr_q, eff, addr_q;
  logic [7:0] data_q [DATA_REGS];
  logic [7:0] wr_off, rd_off;
  logic       wr_go;

  assign eff       = (ptr_q == PTR_NONE) ? 8'h00 : ptr_q;
  assign wr_go     = rx_stb && (ptr_q != PTR_NONE) && in_win(ptr_q);
  assign rx_accept = (ptr_q == PTR_NONE) ? in_win(rx_byte) : in_win(ptr_q);
  assign rd_ok     = in_win(eff);
  assign wr_off    = ptr_q - SYS_BASE;
  assign rd_off    = eff - SYS_BASE;

  for (genvar g = 0; g < DATA_REGS; g++) begin : g_data
    if (g == 0) begin : g_status
      assign data_q[g] = status_in;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             data_q[g] <= 8'h00;
        else if (wr_go && ptr_q == 8'(g))       data_q[g] <= rx_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_byte      <= 8'h00;
      addr_q        <= {1'b0, DEV_ADDR};
      in_off_delay  <= IN_DLY_RST;
      out_off_delay <= OUT_DLY_RST;
    end else if (wr_go && ptr_q >= SYS_BASE) begin
      case (wr_off)
        8'd1:    cmd_byte      <= rx_byte;
        8'd2:    addr_q        <= rx_byte;
        8'd3:    in_off_delay  <= rx_byte;
        8'd4:    out_off_delay <= rx_byte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_active <= DEV_ADDR;
    else if (stop_det)
      addr_active <= (addr_q >= {1'b0, ADDR_MIN} && addr_q <= {1'b0, ADDR_MAX})
                     ? addr_q[6:0] : DEV_ADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr_q <= PTR_NONE;
    else if (ptr_clear)          ptr_q <= PTR_NONE;
    else if (rx_stb) begin
      if (ptr_q == PTR_NONE) begin
        if (in_win(rx_byte))     ptr_q <= rx_byte;
      end else if (wr_go)        ptr_q <= ptr_q + 8'd1;
    end else if (rd_adv)         ptr_q <= eff + 8'd1;
  end

  always_comb begin
    rd_data = 8'hFF;
    if (eff < DATA_END) rd_data = data_q[eff[IDX_W-1:0]];
    else begin
      case (rd_off)
        8'd0:    rd_data = VERSION;
        8'd1:    rd_data = cmd_byte;
        8'd2:    rd_data = addr_q;
        8'd3:    rd_data = in_off_delay;
        8'd4:    rd_data = out_off_delay;
        default: rd_data = 8'hFF;
      endcase
    end
  end

  assign out_lines = data_q[1];
endmodule

// File: rtl/i2c_dual_window_target.sv
module i2c_dual_window_target #(
  parameter int         DATA_REGS   = 8,
  parameter logic [7:0] SYS_BASE    = 8'h20,
  parameter logic [6:0] DEV_ADDR    = 7'h4F,
  parameter logic [6:0] ADDR_MIN    = 7'h20,
  parameter logic [6:0] ADDR_MAX    = 7'h4F,
  parameter logic [7:0] VERSION     = 8'd2,
  parameter logic [7:0] IN_DLY_RST  = 8'h20,
  parameter logic [7:0] OUT_DLY_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] status_in,
  output logic [7:0] out_lines,
  output logic [6:0] addr_active,
  output logic [7:0] cmd_byte,
  output logic [7:0] in_off_delay,
  output logic [7:0] out_off_delay
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       rx_accept, rd_ok, ptr_clear, rx_stb, rd_adv;
  logic [7:0] rd_data, rx_byte;

  i2cdw_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cdw_link u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(addr_active), .rx_accept(rx_accept), .rd_ok(rd_ok),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr_clear(ptr_clear),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rd_adv(rd_adv)
  );

  i2cdw_regbank #(
    .DATA_REGS(DATA_REGS), .SYS_BASE(SYS_BASE), .DEV_ADDR(DEV_ADDR),
    .ADDR_MIN(ADDR_MIN), .ADDR_MAX(ADDR_MAX), .VERSION(VERSION),
    .IN_DLY_RST(IN_DLY_RST), .OUT_DLY_RST(OUT_DLY_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ptr_clear(ptr_clear), .rx_stb(rx_stb),
    .rx_byte(rx_byte), .rd_adv(rd_adv), .stop_det(stop_det),
    .status_in(status_in), .rx_accept(rx_accept), .rd_ok(rd_ok),
    .rd_data(rd_data), .out_lines(out_lines), .cmd_byte(cmd_byte),
    .addr_active(addr_active), .in_off_delay(in_off_delay),
    .out_off_delay(out_off_delay)
  );
endmodule

// File: rtl/i2cdw_checker.sv
module i2cdw_checker #(
  parameter logic [6:0] ADDR_MIN = 7'h20,
  parameter logic [6:0] ADDR_MAX = 7'h4F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       rx_stb,
  input logic       rx_accept,
  input logic [7:0] out_lines,
  input logic [6:0] addr_active
);
  a_r9_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  a_r3_refused_byte_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && !rx_accept) |=> !sda_oe);

  a_r6_lines_move_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_stb) |-> $stable(out_lines));

  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_active >= ADDR_MIN) && (addr_active <= ADDR_MAX));

  a_r8_addr_moves_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_det) |-> $stable(addr_active));
endmodule

bind i2c_dual_window_target i2cdw_checker #(
  .ADDR_MIN(ADDR_MIN), .ADDR_MAX(ADDR_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .rx_stb(rx_stb),
  .rx_accept(rx_accept), .out_lines(out_lines), .addr_active(addr_active)
);

// File: tb/i2c_dual_window_target_bench.sv
`timescale 1ns/1ps
module i2c_dual_window_target_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] status_in = 8'h5A;
  logic       sda_oe;
  logic [7:0] out_lines, cmd_byte, in_off_delay, out_off_delay;
  logic [6:0] addr_active;
  wire        sda_line = sda_m & ~sda_oe;
  int         n_chk = 0, n_bad = 0, r9_viol = 0;
  logic       scl_prev = 1'b1, oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  i2c_dual_window_target u_i2c_dual_window_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .status_in(status_in), .out_lines(out_lines), .addr_active(addr_active),
    .cmd_byte(cmd_byte), .in_off_delay(in_off_delay), .out_off_delay(out_off_delay)
  );

  // table entries: {pointer, data}
  localparam logic [15:0] VEC [8] = '{16'h01A5, 16'h023C, 16'h0781, 16'h2105,
                                      16'h2311, 16'h24EE, 16'h0500, 16'h0642};

  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) r9_viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0;
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); acked = !sda_line; scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_line; scl_m = 1'b0;
    end
    q(); sda_m = ~ack; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic write1(input logic [6:0] dev, input logic [7:0] ptr, input logic [7:0] d,
                        output logic ap, output logic ad);
    logic a;
    bus_start(); send_byte({dev, 1'b0}, a); send_byte(ptr, ap); send_byte(d, ad); bus_stop();
  endtask

  task automatic read1(input logic [6:0] dev, input logic [7:0] ptr, output logic [7:0] d);
    logic a;
    bus_start(); send_byte({dev, 1'b0}, a); send_byte(ptr, a);
    bus_start(); send_byte({dev, 1'b1}, a); recv_byte(d, 1'b0); bus_stop();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic a, ap, ad;
    logic [7:0] d, d1, d2;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 sda released", sda_oe, 1'b0);
    chk("R10 out_lines", out_lines, 8'h00);
    chk("R10 address", addr_active, 7'h4F);
    chk("R7 cmd reset", cmd_byte, 8'h00);
    chk("R7 in delay reset", in_off_delay, 8'h20);
    chk("R7 out delay reset", out_off_delay, 8'hFF);
    read1(7'h4F, 8'h20, d); chk("R7 version", d, 8'h02);
    read1(7'h4F, 8'h22, d); chk("R7 addr byte reset", d, 8'h4F);

    for (int i = 0; i < 8; i++) begin
      write1(7'h4F, VEC[i][15:8], VEC[i][7:0], ap, ad);
      chk("R2 table pointer ack", ap, 1'b1);
      chk("R3 table data ack", ad, 1'b1);
      read1(7'h4F, VEC[i][15:8], d);
      chk("R3 table readback", d, VEC[i][7:0]);
    end
    chk("R6 out_lines from reg1", out_lines, 8'hA5);
    chk("R7 cmd written", cmd_byte, 8'h05);
    chk("R7 in delay written", in_off_delay, 8'h11);
    chk("R7 out delay written", out_off_delay, 8'hEE);

    // R4: write addressing with no data leaves the pointer at the sentinel
    bus_start(); send_byte({7'h4F, 1'b0}, a);
    bus_start(); send_byte({7'h4F, 1'b1}, a);
    recv_byte(d, 1'b1); recv_byte(d1, 1'b1); recv_byte(d2, 1'b0); bus_stop();
    chk("R4 sentinel read reg0", d, 8'h5A);
    chk("R4 advance reg1", d1, 8'hA5);
    chk("R4 advance reg2", d2, 8'h3C);

    // R3: burst write with auto increment
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h03, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h03, a);
    bus_start(); send_byte({7'h4F, 1'b1}, a);
    recv_byte(d, 1'b1); recv_byte(d1, 1'b1); recv_byte(d2, 1'b0); bus_stop();
    chk("R3 burst reg3", d, 8'h11);
    chk("R3 burst reg4", d1, 8'h22);
    chk("R3 burst reg5", d2, 8'h33);

    // R3: crossing from 7 to 8
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h07, a);
    send_byte(8'h99, ad); chk("R3 byte at 7 acked", ad, 1'b1);
    send_byte(8'h77, ad); chk("R3 byte at 8 refused", ad, 1'b0);
    bus_stop();
    read1(7'h4F, 8'h07, d); chk("R3 reg7 kept", d, 8'h99);

    // R2: pointer window edges
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h08, ap); bus_stop();
    chk("R2 pointer 0x08 nack", ap, 1'b0);
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h1F, ap); bus_stop();
    chk("R2 pointer 0x1F nack", ap, 1'b0);
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h25, ap); bus_stop();
    chk("R2 pointer 0x25 nack", ap, 1'b0);
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h24, ap); bus_stop();
    chk("R2 pointer 0x24 ack", ap, 1'b1);

    // R5: read running off the upper window
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h24, a);
    bus_start(); send_byte({7'h4F, 1'b1}, a);
    recv_byte(d, 1'b1); recv_byte(d1, 1'b0); bus_stop();
    chk("R5 last valid byte", d, 8'hEE);
    chk("R5 out of range reads FF", d1, 8'hFF);
    bus_start(); send_byte({7'h4F, 1'b1}, a); recv_byte(d, 1'b0); bus_stop();
    chk("R5 pointer stays out of range", d, 8'hFF);

    // R1: foreign addresses
    bus_start(); send_byte({7'h50, 1'b0}, a); bus_stop();
    chk("R1 address 0x50 ignored", a, 1'b0);
    bus_start(); send_byte({7'h4E, 1'b1}, a); bus_stop();
    chk("R1 address 0x4E ignored", a, 1'b0);
    chk("R1 no drive after foreign address", sda_oe, 1'b0);

    // R6: register 0 is read-only and live
    write1(7'h4F, 8'h00, 8'h00, ap, ad);
    chk("R6 reg0 write acked", ad, 1'b1);
    read1(7'h4F, 8'h00, d); chk("R6 reg0 status", d, 8'h5A);
    status_in = 8'hC3;
    read1(7'h4F, 8'h00, d); chk("R6 reg0 live status", d, 8'hC3);

    // R7: version is read-only
    write1(7'h4F, 8'h20, 8'h77, ap, ad);
    chk("R7 version write acked", ad, 1'b1);
    read1(7'h4F, 8'h20, d); chk("R7 version unchanged", d, 8'h02);

    // R8: address change waits for STOP
    bus_start(); send_byte({7'h4F, 1'b0}, a); send_byte(8'h22, a); send_byte(8'h30, ad);
    chk("R8 address still old before stop", addr_active, 7'h4F);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R8 address after stop", addr_active, 7'h30);
    bus_start(); send_byte({7'h4F, 1'b0}, a); bus_stop();
    chk("R8 old address ignored", a, 1'b0);
    read1(7'h30, 8'h22, d); chk("R8 addr byte via new address", d, 8'h30);
    write1(7'h30, 8'h22, 8'h10, ap, ad);
    repeat (4) @(negedge clk);
    chk("R8 below range falls back", addr_active, 7'h4F);
    read1(7'h4F, 8'h22, d); chk("R8 raw addr byte kept", d, 8'h10);

    chk("R9 no SDA change while SCL high", r9_viol, 0);
    finish_run();
  end
endmodule